// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block sequences one-byte stack transfers for a small 8-bit processor core. It executes two operations: pushing the accumulator onto the stack and pulling a byte from the stack into the accumulator. It owns the 8-bit stack pointer. Every stack access goes to memory page 0x01, with the pointer as the low address byte. A push captures the accumulator, writes it, and moves the pointer down. A pull moves the pointer up, reads the byte into an internal data buffer, and in its last cycle hands the byte to the accumulator together with the negative and zero flags.

The core raises `start_i` for one cycle with `pull_i` selecting the operation. The sequencer then walks a fixed number of cycles and marks the final one with `done_o`. While a sequence runs, further start requests are dropped.

States and transitions:
- IDLE goes to PUSH_WR on a start with `pull_i`=0.
- IDLE goes to PULL_RD on a start with `pull_i`=1.
- PUSH_WR always goes to PUSH_FIN.
- PUSH_FIN always goes to IDLE.
- PULL_RD always goes to PULL_WAIT.
- PULL_WAIT always goes to PULL_FIN.
- PULL_FIN always goes to IDLE.

Top module: `stk_seq`

## Requirements
- R1: A start with `pull_i`=0 seen in IDLE begins a push. In the first push cycle `mem_we_o`=1, `mem_addr_o`={0x01, sp}, and `mem_wdata_o` equals `acc_i` as sampled with the start.
- R2: The second push cycle has `mem_we_o`=0 and `mem_re_o`=0 and `done_o`=1. A push is exactly two cycles long.
- R3: A start with `pull_i`=1 seen in IDLE begins a pull. In its first cycle `mem_re_o`=1, `mem_addr_o`={0x01, sp+1}, and `mem_rdata_i` is captured. The second cycle makes no bus access. The third cycle has `done_o`=1.
- R4: In the third pull cycle `acc_we_o`=1 and `acc_o` equals the captured byte. `flag_n_o` equals bit 7 of that byte, and `flag_z_o`=1 exactly when the byte is 0x00.
- R5: `done_o` is high only in the final cycle of a sequence, for one cycle. `acc_we_o` is never high during a push, so a push changes no flags.
- R6: A push decrements `sp_o` after its write. A pull increments `sp_o` at its read. The pointer wraps modulo 256.
- R7: A start raised in any cycle other than IDLE, including the final cycle, is ignored. It starts no sequence and touches neither the bus nor the pointer.
- R8: After reset `sp_o`=0xFF, the sequencer is IDLE, and `done_o`, `mem_we_o`, `mem_re_o` and `acc_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation, one cycle |
| pull_i | input | 1 | Operation select: 1 pull, 0 push |
| acc_i | input | 8 | Current accumulator value for a push |
| mem_rdata_i | input | 8 | Memory read data, valid in the address cycle |
| mem_addr_o | output | 16 | Stack address {0x01, pointer} |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| sp_o | output | 8 | Stack pointer |
| done_o | output | 1 | Final cycle of a sequence |
| acc_we_o | output | 1 | Accumulator and N/Z load strobe |
| acc_o | output | 8 | Value to load into the accumulator |
| flag_n_o | output | 1 | Negative flag for the loaded value |
| flag_z_o | output | 1 | Zero flag for the loaded value |

## Verification
A wrong state shows up at the ports within one cycle as a misplaced `done_o` or a strobe in the wrong cycle. A pointer that moves wrongly shows up on the next access as a wrong `mem_addr_o`. It also shows up as a value that does not come back in last-in, first-out order once the pointer has wrapped. A corrupted data buffer is seen two cycles after the read, in the final pull cycle, as a wrong `acc_o` or wrong flags.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PUSH_WR   = 3'd1,
        ST_PUSH_FIN  = 3'd2,
        ST_PULL_RD   = 3'd3,
        ST_PULL_WAIT = 3'd4,
        ST_PULL_FIN  = 3'd5
    } stk_state_e;
endpackage

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pull_i,
    output stk_state_e state_o
);
    stk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = pull_i ? ST_PULL_RD : ST_PUSH_WR;
            ST_PUSH_WR:   state_d = ST_PUSH_FIN;
            ST_PUSH_FIN:  state_d = ST_IDLE;
            ST_PULL_RD:   state_d = ST_PULL_WAIT;
            ST_PULL_WAIT: state_d = ST_PULL_FIN;
            ST_PULL_FIN:  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    assert_push_two_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PUSH_WR |=> state_q == ST_PUSH_FIN);
    assert_pull_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PULL_RD |=> state_q == ST_PULL_WAIT);
    assert_pull_fin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PULL_WAIT |=> state_q == ST_PULL_FIN);
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> !(state_q inside {ST_PUSH_WR, ST_PULL_RD}));
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int          PTR_W    = 8,
    parameter logic [7:0]  SP_RESET = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] sp_up_o
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
    logic [PTR_W-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sp_q <= PTR_W'(SP_RESET);
        else if (dec_i) sp_q <= sp_q - ONE;
        else if (inc_i) sp_q <= sp_q + ONE;
    end

    assign sp_o    = sp_q;
    assign sp_up_o = sp_q + ONE;

    assert_dec_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> sp_q == $past(sp_q) - ONE);
    assert_inc_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> sp_q == $past(sp_q) + ONE);
    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_i && dec_i));
endmodule

// File: rtl/stk_buf.sv
module stk_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_acc_i,
    input  logic              load_mem_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] mem_i,
    output logic [DATA_W-1:0] buf_o
);
    logic [DATA_W-1:0] buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          buf_q <= '0;
        else if (load_acc_i) buf_q <= acc_i;
        else if (load_mem_i) buf_q <= mem_i;
    end

    assign buf_o = buf_q;

    assert_capture_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mem_i && !load_acc_i) |=> buf_q == $past(mem_i));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] PAGE     = 8'h01,
    parameter logic [7:0] SP_RESET = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                pull_i,
    input  logic [DATA_W-1:0]   acc_i,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic [2*DATA_W-1:0] mem_addr_o,
    output logic                mem_we_o,
    output logic                mem_re_o,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic [DATA_W-1:0]   sp_o,
    output logic                done_o,
    output logic                acc_we_o,
    output logic [DATA_W-1:0]   acc_o,
    output logic                flag_n_o,
    output logic                flag_z_o
);
    localparam int ADDR_W = 2 * DATA_W;

    stk_state_e        state;
    logic [DATA_W-1:0] sp, sp_up, buf_val;
    logic              accept;

    assign accept = (state == ST_IDLE) && start_i;

    stk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pull_i(pull_i), .state_o(state)
    );

    stk_ptr #(.PTR_W(DATA_W), .SP_RESET(SP_RESET)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .dec_i(state == ST_PUSH_WR), .inc_i(state == ST_PULL_RD),
        .sp_o(sp), .sp_up_o(sp_up)
    );

    stk_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .load_acc_i(accept && !pull_i), .load_mem_i(state == ST_PULL_RD),
        .acc_i(acc_i), .mem_i(mem_rdata_i), .buf_o(buf_val)
    );

    always_comb begin
        mem_addr_o = ADDR_W'({PAGE, sp});
        mem_we_o   = 1'b0;
        mem_re_o   = 1'b0;
        done_o     = 1'b0;
        acc_we_o   = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_PUSH_WR:   mem_we_o = 1'b1;
            ST_PUSH_FIN:  done_o = 1'b1;
            ST_PULL_RD: begin
                mem_re_o   = 1'b1;
                mem_addr_o = ADDR_W'({PAGE, sp_up});
            end
            ST_PULL_WAIT: ;
            ST_PULL_FIN: begin
                done_o   = 1'b1;
                acc_we_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_wdata_o = buf_val;
    assign sp_o        = sp;
    assign acc_o       = buf_val;
    assign flag_n_o    = buf_val[DATA_W-1];
    assign flag_z_o    = (buf_val == '0);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_push_no_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !acc_we_o);
    assert_write_then_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> done_o && !mem_we_o && !mem_re_o);
    assert_read_no_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> !done_o && !mem_re_o && !mem_we_o);
    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> ##1 acc_we_o && acc_o == $past(mem_rdata_i, 2));
endmodule

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, pull_i = 1'b0;
    logic [7:0]  acc_i = '0, mem_rdata_i;
    logic [15:0] mem_addr_o;
    logic        mem_we_o, mem_re_o, done_o, acc_we_o, flag_n_o, flag_z_o;
    logic [7:0]  mem_wdata_o, sp_o, acc_o;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] bmem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_sp;

    always #10 clk = ~clk;

    stk_seq u_stk_seq (.*);

    assign mem_rdata_i = bmem[mem_addr_o[7:0]];
    always @(posedge clk) if (mem_we_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] v);
        @(negedge clk); start_i = 1; pull_i = 0; acc_i = v;
        @(negedge clk); start_i = 0; acc_i = ~v;
        chk("R1 we", mem_we_o, 1);
        chk("R1 addr", mem_addr_o, {8'h01, exp_sp});
        chk("R1 wdata", mem_wdata_o, v);
        chk("R5 early done", done_o, 0);
        exp_mem[exp_sp] = v;
        exp_sp = exp_sp - 8'd1;
        start_i = 1; pull_i = 1;
        @(negedge clk); start_i = 0;
        chk("R2 done", done_o, 1);
        chk("R2 no bus", {mem_we_o, mem_re_o}, 0);
        chk("R5 push acc_we", acc_we_o, 0);
        chk("R6 dec", sp_o, exp_sp);
        @(negedge clk);
        chk("R7 ignored start", {done_o, mem_we_o, mem_re_o}, 0);
        chk("R7 sp kept", sp_o, exp_sp);
    endtask

    task automatic do_pull();
        logic [7:0] e;
        @(negedge clk); start_i = 1; pull_i = 1;
        @(negedge clk);
        exp_sp = exp_sp + 8'd1;
        e = exp_mem[exp_sp];
        chk("R3 re", {mem_re_o, mem_we_o}, 2'b10);
        chk("R3 addr", mem_addr_o, {8'h01, exp_sp});
        chk("R5 early done", done_o, 0);
        pull_i = 0;
        @(negedge clk); start_i = 0;
        chk("R3 idle cycle", {mem_re_o, mem_we_o, done_o, acc_we_o}, 0);
        chk("R6 inc", sp_o, exp_sp);
        start_i = 1;
        @(negedge clk); start_i = 0;
        chk("R3 done", done_o, 1);
        chk("R4 acc_we", acc_we_o, 1);
        chk("R4 acc", acc_o, e);
        chk("R4 n", flag_n_o, e[7]);
        chk("R4 z", flag_z_o, e == 8'h00);
        @(negedge clk);
        chk("R7 ignored start", {done_o, mem_we_o, mem_re_o, acc_we_o}, 0);
        chk("R5 single done", done_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin bmem[i] = 8'h5A; exp_mem[i] = 8'h5A; end
        exp_sp = 8'hFF;
        repeat (2) @(negedge clk);
        chk("R8 sp", sp_o, 8'hFF);
        chk("R8 outs", {done_o, mem_we_o, mem_re_o, acc_we_o}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R8 idle", {done_o, mem_we_o, mem_re_o, acc_we_o}, 0);
        do_push(8'h00); do_push(8'h80); do_push(8'h7F);
        do_pull(); do_pull(); do_pull();
        for (int i = 0; i < 260; i++) do_push(8'((i * 37 + 5) & 255));
        for (int i = 0; i < 260; i++) do_pull();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule